// File: doc/BRIEF.md
# Phase-Accumulator Fractional Clock Synthesizer

This block derives a slower clock from one of three faster source clocks by adding a programmable increment into a phase accumulator. Each source clock reaches the block as a one-cycle step strobe in the system clock domain. The accumulator advances only on strobes from the chosen source. The synthesized clock is the most significant active bit of the accumulator, so its average frequency is the source rate times the increment over the accumulator modulus.

Two resolution settings are available. In double-resolution mode, the accumulator wraps at 2^29 and the output is bit 28, which gives fout = fin × inc / 2^29. In normal mode, the accumulator wraps at 2^28 and the output is bit 27, which gives fout = fin × inc / 2^28. After reset the block is in double-resolution mode. Software controls the block through four word registers. The register addresses are: 0 for the increment (bits 28:0), 1 for the source select (bits 1:0), 2 for the enable (bit 0), and 3 for the mode (bit 0, where 1 means double resolution). Writes are registered. Reads are combinational from the read address.

Top module: `dto_synth`

## Requirements
- R1: After reset, clk_out is 0 and the registers read back as follows: increment 0, select 0, enable 0, mode 1.
- R2: While the enable is 0, clk_out is 0 and the accumulator is held at zero. Source strobes then have no effect. After re-enabling, the phase starts from zero.
- R3: With mode 1, each selected strobe adds the increment modulo 2^29. clk_out equals accumulator bit 28 in the cycle after the strobe.
- R4: With mode 0, each selected strobe adds the increment modulo 2^28, and bit 28 stays clear. clk_out equals accumulator bit 27.
- R5: Only the strobe whose index equals the select register advances the accumulator. Strobes on the other sources are ignored.
- R6: A new increment is used from the next strobe onward, and the accumulated phase is not reset.
- R7: An increment of zero keeps clk_out at 0 for any number of strobes.
- R8: A write to the select register while the enable is 1 is ignored, and the readback is unchanged.
- R9: A write to the select register with a value of 3 or more is ignored.
- R10: Only bit 0 of the enable register is stored, and a read returns it in bit 0 with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_stb | input | 3 | Per-source step strobes, one bit per source clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| clk_out | output | 1 | Synthesized clock |

## Verification
A corrupted accumulator bit changes the phase of clk_out, but the change becomes visible only when that bit's weight carries into the output bit. For a small increment this can take many strobes. The bench therefore compares clk_out after every strobe against its own phase model, using increments with both low-order and high-order bits set. A wrong mode mask or a wrong wrap point shows up within one output period. A counted strobe from the wrong source toggles the output on the very next strobe, because the bench uses an increment of half the modulus.

// File: rtl/dto_pkg.sv
package dto_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_INC  = 2'd0,
    REG_SEL  = 2'd1,
    REG_ENA  = 2'd2,
    REG_MODE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dto_regs.sv
module dto_regs
  import dto_pkg::*;
#(
  parameter int ACC_W   = 29,
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [ACC_W-1:0]  inc_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              ena_q,
  output logic              mode_q
);
  logic [ACC_W-1:0] inc_d;
  logic [SEL_W-1:0] sel_d;
  logic             ena_d;
  logic             mode_d;
  logic             sel_ok;

  assign sel_ok = (wr_data < DATA_W'(NUM_SRC)) && !ena_q;

  always_comb begin
    inc_d  = inc_q;
    sel_d  = sel_q;
    ena_d  = ena_q;
    mode_d = mode_q;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        REG_INC:  inc_d  = wr_data[ACC_W-1:0];
        REG_SEL:  if (sel_ok) sel_d = wr_data[SEL_W-1:0];
        REG_ENA:  ena_d  = wr_data[0];
        REG_MODE: mode_d = wr_data[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q  <= '0;
      sel_q  <= '0;
      ena_q  <= 1'b0;
      mode_q <= 1'b1;
    end else begin
      inc_q  <= inc_d;
      sel_q  <= sel_d;
      ena_q  <= ena_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      REG_INC:  rd_data[ACC_W-1:0] = inc_q;
      REG_SEL:  rd_data[SEL_W-1:0] = sel_q;
      REG_ENA:  rd_data[0]         = ena_q;
      REG_MODE: rd_data[0]         = mode_q;
      default:  ;
    endcase
  end
endmodule

// File: rtl/dto_src_sel.sv
module dto_src_sel #(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] src_stb,
  input  logic [SEL_W-1:0]   sel_q,
  output logic               step
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = src_stb[g] && (sel_q == SEL_W'(g));
  end

  assign step = |hit;
endmodule

// File: rtl/dto_accum.sv
module dto_accum #(
  parameter int ACC_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ena,
  input  logic             mode_dbl,
  input  logic             step,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc_q,
  output logic             clk_out
);
  localparam int TOP_DBL = ACC_W - 1;
  localparam int TOP_NRM = ACC_W - 2;

  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] acc_d;

  assign sum = acc_q + inc;

  always_comb begin
    acc_d = acc_q;
    if (!ena) begin
      acc_d = '0;
    end else if (step) begin
      if (mode_dbl) acc_d = sum;
      else          acc_d = {1'b0, sum[TOP_NRM:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign clk_out = ena && (mode_dbl ? acc_q[TOP_DBL] : acc_q[TOP_NRM]);
endmodule

// File: rtl/dto_synth.sv
module dto_synth
  import dto_pkg::*;
#(
  parameter int ACC_W   = 29,
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_stb,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               clk_out
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [1:0]       rst_sync;
  logic             rst_n_s;
  logic [ACC_W-1:0] inc_q;
  logic [SEL_W-1:0] sel_q;
  logic             ena_q;
  logic             mode_q;
  logic             step;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  dto_regs #(.ACC_W(ACC_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .inc_q(inc_q), .sel_q(sel_q), .ena_q(ena_q), .mode_q(mode_q)
  );

  dto_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .src_stb(src_stb), .sel_q(sel_q), .step(step)
  );

  dto_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n_s), .ena(ena_q), .mode_dbl(mode_q),
    .step(step), .inc(inc_q), .acc_q(acc_q), .clk_out(clk_out)
  );
endmodule

// File: rtl/dto_synth_chk.sv
module dto_synth_chk
  import dto_pkg::*;
#(
  parameter int ACC_W   = 29,
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_out,
  input logic              ena_q,
  input logic              mode_q,
  input logic              step,
  input logic [ACC_W-1:0]  inc_q,
  input logic [ACC_W-1:0]  acc_q,
  input logic [SEL_W-1:0]  sel_q,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr
);
  logic ena_wr;
  assign ena_wr = wr_en && (wr_addr == REG_ENA);

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_q |-> !clk_out);                                            // R2
  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_q |=> (acc_q == '0));                                       // R2
  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q && !step && !ena_wr) |=> $stable(acc_q));                 // R5
  AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q && step && !mode_q) |=> !acc_q[ACC_W-1]);                 // R4
  AST_ZERO_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q && step && mode_q && inc_q == '0 && !ena_wr) |=> $stable(acc_q)); // R7
  AST_SEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ena_q |=> $stable(sel_q));                                       // R8
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_q) < NUM_SRC);                                          // R9
endmodule

bind dto_synth dto_synth_chk #(.ACC_W(ACC_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .clk_out(clk_out), .ena_q(ena_q),
  .mode_q(mode_q), .step(step), .inc_q(inc_q), .acc_q(acc_q),
  .sel_q(sel_q), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/test_dto_synth.sv
module test_dto_synth;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  src_stb;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        clk_out;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [28:0] m_acc;
  logic [28:0] m_inc;
  logic        m_dbl;
  logic        m_ena;
  int          m_sel;

  always #2 clk = ~clk;

  dto_synth i_dto_synth (
    .clk(clk), .rst_n(rst_n), .src_stb(src_stb), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .clk_out(clk_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd0) m_inc = d[28:0];
    if (a == 2'd2) begin m_ena = d[0]; if (!d[0]) m_acc = '0; end
    if (a == 2'd3) m_dbl = d[0];
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic exp_out();
    return m_ena && (m_dbl ? m_acc[28] : m_acc[27]);
  endfunction

  task automatic pulse(input int idx);
    @(negedge clk);
    src_stb = 3'b000; src_stb[idx] = 1'b1;
    @(negedge clk);
    src_stb = 3'b000;
    if (m_ena && idx == m_sel) begin
      m_acc = m_acc + m_inc;
      if (!m_dbl) m_acc[28] = 1'b0;
    end
  endtask

  task automatic run(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      pulse(m_sel);
      chk(req, {31'd0, clk_out}, {31'd0, exp_out()});
    end
  endtask

  task automatic setup(input logic dbl, input logic [28:0] inc, input int sel);
    wr(2'd2, 32'd0);
    wr(2'd3, {31'd0, dbl});
    wr(2'd0, {3'd0, inc});
    wr(2'd1, sel);
    m_sel = sel;
    wr(2'd2, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 clk_out", {31'd0, clk_out}, 32'd0);
    rd(2'd0, d); chk("R1 inc", d, 32'd0);
    rd(2'd1, d); chk("R1 sel", d, 32'd0);
    rd(2'd2, d); chk("R1 ena", d, 32'd0);
    rd(2'd3, d); chk("R1 mode", d, 32'd1);
  endtask

  task automatic t_double;
    setup(1'b1, 29'h4000000, 0);
    run("R3 eighth", 16);
    setup(1'b1, 29'h0123457, 1);
    run("R3 odd inc", 40);
    setup(1'b1, 29'h1F00001, 2);
    run("R3 wrap", 40);
  endtask

  task automatic t_normal;
    setup(1'b0, 29'h1000000, 0);
    run("R4 sixteenth", 32);
    setup(1'b0, 29'h1ABCDEF, 1);
    run("R4 odd inc", 40);
    setup(1'b0, 29'h10800000, 2);
    run("R4 high bit", 20);
  endtask

  task automatic t_source;
    setup(1'b1, 29'h10000000, 2);
    for (int r = 0; r < 3; r++) begin
      pulse(0); chk("R5 src0 ignored", {31'd0, clk_out}, {31'd0, exp_out()});
      pulse(1); chk("R5 src1 ignored", {31'd0, clk_out}, {31'd0, exp_out()});
      pulse(2); chk("R5 src2 counted", {31'd0, clk_out}, {31'd0, exp_out()});
    end
  endtask

  task automatic t_inc_change;
    setup(1'b1, 29'h4000000, 0);
    run("R6 before", 3);
    wr(2'd0, 32'h0800_0000);
    chk("R6 no jump", {31'd0, clk_out}, {31'd0, exp_out()});
    run("R6 after", 8);
  endtask

  task automatic t_zero;
    setup(1'b1, 29'h0, 1);
    for (int i = 0; i < 20; i++) begin
      pulse(1);
      chk("R7 zero inc", {31'd0, clk_out}, 32'd0);
    end
  endtask

  task automatic t_disable;
    setup(1'b1, 29'h6000000, 0);
    run("R2 pre", 3);
    wr(2'd2, 32'd0);
    chk("R2 off low", {31'd0, clk_out}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      pulse(0);
      chk("R2 off strobe", {31'd0, clk_out}, 32'd0);
    end
    wr(2'd2, 32'd1);
    chk("R2 restart low", {31'd0, clk_out}, 32'd0);
    run("R2 restart phase", 10);
  endtask

  task automatic t_sel_rules;
    logic [31:0] d;
    setup(1'b1, 29'h100, 1);
    wr(2'd1, 32'd2);
    rd(2'd1, d); chk("R8 locked", d, 32'd1);
    wr(2'd2, 32'd0);
    wr(2'd1, 32'd3);
    rd(2'd1, d); chk("R9 out of range", d, 32'd1);
    wr(2'd1, 32'h0000_0100);
    rd(2'd1, d); chk("R9 wide value", d, 32'd1);
    wr(2'd1, 32'd2);
    rd(2'd1, d); chk("R9 legal", d, 32'd2);
  endtask

  task automatic t_ena_bits;
    logic [31:0] d;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R10 set", d, 32'd1);
    wr(2'd2, 32'hFFFF_FFFE);
    rd(2'd2, d); chk("R10 clear", d, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_stb = '0; wr_en = 1'b0; wr_addr = '0;
    wr_data = '0; rd_addr = '0;
    m_acc = '0; m_inc = '0; m_dbl = 1'b1; m_ena = 1'b0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_double();
    t_normal();
    t_source();
    t_inc_change();
    t_zero();
    t_disable();
    t_sel_rules();
    t_ena_bits();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule